// File: doc/BRIEF.md
# Six-Step Commutation Gate Sequencer

This block sits between three per-phase PWM waveforms and the six gate drivers of a three-phase bridge that runs in trapezoidal commutation. A state machine with six states, `STEP0` to `STEP5`, holds the commutation step. Each single-cycle pulse on `adv_i` moves it to the following step. Every step has an entry in a table that assigns each phase a 2-bit override code. The code lets PWM through on the phase's high-side gate only, on its low-side gate only, or on neither. In each step, exactly one phase is high-side only, a second phase is low-side only, and the third is held off.

A step change does not affect the gates straight away. The codes for the current step are copied into a register on the clock edge that samples `cyc_start_i`, the start-of-PWM-cycle strobe. The gate outputs are then formed combinationally from the registered codes and the live PWM inputs. This keeps a commutation change from cutting a PWM pulse in the middle.

A masked gate is always driven low. The high and low pins of a phase are controlled separately rather than as a complementary pair. After reset the step is `STEP0` and every phase is held off until the first cycle-start strobe.

Top module: `six_step_override_seq`

## Requirements
- R1: While reset is asserted, and after reset until the first `cyc_start_i` pulse, all six gate outputs are low whatever the PWM inputs are.
- R2: The step state machine has the transitions `STEP0`→`STEP1`→`STEP2`→`STEP3`→`STEP4`→`STEP5`→`STEP0`. It takes one transition on each clock edge where `adv_i` is high and holds its state otherwise.
- R3: The override codes per step, given as (phase A, phase B, phase C), are: `STEP0` (1,2,3), `STEP1` (1,3,2), `STEP2` (3,1,2), `STEP3` (2,1,3), `STEP4` (2,3,1), `STEP5` (3,2,1). Phase A is bit 0 of each gate and PWM vector, phase B is bit 1 and phase C is bit 2.
- R4: A phase with code 1 drives its high gate equal to its own PWM input and holds its low gate low.
- R5: A phase with code 2 drives its low gate equal to its own PWM input and holds its high gate low.
- R6: A phase with code 3 holds both of its gates low for every PWM value. Code 0, which is not used in the table, would pass PWM to both gates.
- R7: Codes for a new step take effect only from the clock edge that samples `cyc_start_i` high. If `adv_i` pulses without a cycle-start strobe, the gate outputs still follow the previous step.
- R8: When `adv_i` and `cyc_start_i` are high on the same edge, the codes latched are those of the step before the advance. The advanced step is applied at the next cycle-start strobe.
- R9: The high and low gates of one phase are never high in the same cycle, and at most two of the six gates are high at any time.
- R10: Each active gate follows only its own phase's PWM input. A PWM pulse on a phase that is off in the current step produces no gate activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 3 | PWM waveform per phase (bit 0 A, bit 1 B, bit 2 C) |
| adv_i | input | 1 | Commutation advance strobe, one cycle wide |
| cyc_start_i | input | 1 | Start-of-PWM-cycle strobe, one cycle wide |
| gate_hi_o | output | 3 | High-side gate drive per phase |
| gate_lo_o | output | 3 | Low-side gate drive per phase |

## Verification
A strobe on `adv_i` or `cyc_start_i` acts on the first rising edge that samples it, so the new step or the new codes are in place one clock after the strobe is driven. A change on `pwm_i` reaches the gates in the same cycle, with no register in between. The bench drives every input on the falling edge. It checks gate values one time unit after a PWM change, and after a strobe it checks only once the following falling edge has been reached. It sweeps all eight PWM patterns in each of the six steps over two full revolutions. Advance without cycle start and the coincident-strobe case are each checked at the first sampling point after the relevant edge.

// File: rtl/six_step_pkg.sv
package six_step_pkg;
    localparam int NUM_PHASES = 3;
    localparam int NUM_STEPS  = 6;
    localparam int CODE_W     = 2;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int CODES_W    = NUM_PHASES * CODE_W;

    typedef enum logic [STEP_W-1:0] {
        STEP0 = 3'd0,
        STEP1 = 3'd1,
        STEP2 = 3'd2,
        STEP3 = 3'd3,
        STEP4 = 3'd4,
        STEP5 = 3'd5
    } step_e;

    typedef enum logic [CODE_W-1:0] {
        OVR_PASS = 2'd0,
        OVR_HI   = 2'd1,
        OVR_LO   = 2'd2,
        OVR_OFF  = 2'd3
    } ovr_e;
endpackage

// File: rtl/six_step_stepper.sv
module six_step_stepper
    import six_step_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv_i,
    output step_e step_o
);
    step_e step_q, step_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) step_q <= STEP0;
        else        step_q <= step_nx;
    end

    always_comb begin
        step_nx = step_q;
        if (adv_i) begin
            unique case (step_q)
                STEP0:   step_nx = STEP1;
                STEP1:   step_nx = STEP2;
                STEP2:   step_nx = STEP3;
                STEP3:   step_nx = STEP4;
                STEP4:   step_nx = STEP5;
                STEP5:   step_nx = STEP0;
                default: step_nx = STEP0;
            endcase
        end
    end

    assign step_o = step_q;

    assert_step_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && step_q == STEP5) |=> (step_q == STEP0));
    assert_step_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(step_q));
    assert_step_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && step_q != STEP5) |=> (step_q == step_e'($past(step_q) + 3'd1)));
endmodule

// File: rtl/six_step_code_rom.sv
module six_step_code_rom
    import six_step_pkg::*;
(
    input  step_e              step_i,
    output logic [CODES_W-1:0] codes_o
);
    // Field per phase: A in [1:0], B in [3:2], C in [5:4]
    always_comb begin
        unique case (step_i)
            STEP0:   codes_o = {OVR_OFF, OVR_LO,  OVR_HI };
            STEP1:   codes_o = {OVR_LO,  OVR_OFF, OVR_HI };
            STEP2:   codes_o = {OVR_LO,  OVR_HI,  OVR_OFF};
            STEP3:   codes_o = {OVR_OFF, OVR_HI,  OVR_LO };
            STEP4:   codes_o = {OVR_HI,  OVR_OFF, OVR_LO };
            STEP5:   codes_o = {OVR_HI,  OVR_LO,  OVR_OFF};
            default: codes_o = {OVR_OFF, OVR_OFF, OVR_OFF};
        endcase
    end
endmodule

// File: rtl/six_step_phase_gate.sv
module six_step_phase_gate
    import six_step_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              pwm_i,
    output logic              hi_o,
    output logic              lo_o
);
    always_comb begin
        unique case (ovr_e'(code_i))
            OVR_PASS: begin hi_o = pwm_i; lo_o = pwm_i; end
            OVR_HI:   begin hi_o = pwm_i; lo_o = 1'b0;  end
            OVR_LO:   begin hi_o = 1'b0;  lo_o = pwm_i; end
            OVR_OFF:  begin hi_o = 1'b0;  lo_o = 1'b0;  end
            default:  begin hi_o = 1'b0;  lo_o = 1'b0;  end
        endcase
    end
endmodule

// File: rtl/six_step_override_seq.sv
module six_step_override_seq
    import six_step_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] pwm_i,
    input  logic                  adv_i,
    input  logic                  cyc_start_i,
    output logic [NUM_PHASES-1:0] gate_hi_o,
    output logic [NUM_PHASES-1:0] gate_lo_o
);
    localparam logic [CODES_W-1:0] ALL_OFF = {NUM_PHASES{OVR_OFF}};

    step_e              step;
    logic [CODES_W-1:0] rom_codes;
    logic [CODES_W-1:0] code_q;

    six_step_stepper u_stepper (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv_i  (adv_i),
        .step_o (step)
    );

    six_step_code_rom u_rom (
        .step_i  (step),
        .codes_o (rom_codes)
    );

    // Codes are latched at cycle start only; reset holds every phase off
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           code_q <= ALL_OFF;
        else if (cyc_start_i) code_q <= rom_codes;
    end

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
        six_step_phase_gate u_gate (
            .code_i (code_q[p*CODE_W +: CODE_W]),
            .pwm_i  (pwm_i[p]),
            .hi_o   (gate_hi_o[p]),
            .lo_o   (gate_lo_o[p])
        );

        assert_no_shoot_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_hi_o[p] && gate_lo_o[p]));
        assert_idle_pwm_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !pwm_i[p] |-> (!gate_hi_o[p] && !gate_lo_o[p]));
    end

    assert_codes_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_start_i |=> $stable(code_q));
    assert_two_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gate_hi_o, gate_lo_o}) <= 2);
endmodule

// File: tb/test_six_step_override_seq.sv
module test_six_step_override_seq;
    localparam time CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] pwm_i = 3'b000;
    logic       adv_i = 1'b0;
    logic       cyc_start_i = 1'b0;
    logic [2:0] gate_hi_o;
    logic [2:0] gate_lo_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    six_step_override_seq i_six_step_override_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_i       (pwm_i),
        .adv_i       (adv_i),
        .cyc_start_i (cyc_start_i),
        .gate_hi_o   (gate_hi_o),
        .gate_lo_o   (gate_lo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int hi_ph(int s);
        return s / 2;
    endfunction
    function automatic int lo_ph(int s);
        return ((s + 1) / 2 + 1) % 3;
    endfunction

    // Expected {lo[2:0], hi[2:0]} for step s and PWM pattern p
    function automatic logic [5:0] exp_gates(int s, logic [2:0] p);
        logic [2:0] h, l;
        h = 3'b000;
        l = 3'b000;
        h[hi_ph(s)] = p[hi_ph(s)];
        l[lo_ph(s)] = p[lo_ph(s)];
        return {l, h};
    endfunction

    task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic pulse(logic a, logic c);
        @(negedge clk);
        adv_i       = a;
        cyc_start_i = c;
        @(negedge clk);
        adv_i       = 1'b0;
        cyc_start_i = 1'b0;
    endtask

    task automatic sweep_step(int s);
        int o;
        o = 3 - hi_ph(s) - lo_ph(s);
        for (int p = 0; p < 8; p++) begin
            logic [5:0] e;
            pwm_i = 3'(p);
            #1;
            e = exp_gates(s, 3'(p));
            chk("R3", {gate_lo_o, gate_hi_o}, e);
            chk("R4", {3'b000, gate_hi_o}, {3'b000, e[2:0]});
            chk("R5", {3'b000, gate_lo_o}, {3'b000, e[5:3]});
            chk("R6", {4'b0, gate_hi_o[o], gate_lo_o[o]}, 6'b0);
            chk("R9", {3'b000, gate_hi_o & gate_lo_o}, 6'b0);
            if (p == 1 || p == 2 || p == 4)
                chk("R10", {gate_lo_o, gate_hi_o}, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            pwm_i = 3'(p);
            #1;
            chk("R1", {gate_lo_o, gate_hi_o}, 6'b0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 8; p++) begin
            pwm_i = 3'(p);
            #1;
            chk("R1", {gate_lo_o, gate_hi_o}, 6'b0);
        end

        s = 0;
        for (int it = 0; it < 12; it++) begin
            pwm_i = 3'b111;
            pulse(1'b0, 1'b1);
            #1;
            chk("R2", {gate_lo_o, gate_hi_o}, exp_gates(s, 3'b111));
            sweep_step(s);
            pwm_i = 3'b111;
            pulse(1'b1, 1'b0);
            #1;
            chk("R7", {gate_lo_o, gate_hi_o}, exp_gates(s, 3'b111));
            s = (s + 1) % 6;
        end

        // Coincident strobes: latch the step before the advance
        pwm_i = 3'b111;
        pulse(1'b0, 1'b1);
        #1;
        chk("R8", {gate_lo_o, gate_hi_o}, exp_gates(s, 3'b111));
        pulse(1'b1, 1'b1);
        #1;
        chk("R8", {gate_lo_o, gate_hi_o}, exp_gates(s, 3'b111));
        s = (s + 1) % 6;
        pulse(1'b0, 1'b1);
        #1;
        chk("R8", {gate_lo_o, gate_hi_o}, exp_gates(s, 3'b111));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule